// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a wider physical address. It reads 64-bit table entries from a three-level hierarchy. Each request carries a virtual address and a table-root base. The walker then issues one dependent 64-bit read per level on a valid/ready memory read port, and returns either a physical address or a fault.

The top level has four entries, chosen by the two highest virtual-address bits. The two lower levels are 512-entry tables of 8-byte entries. A directory entry can end the walk early by mapping a 2 MiB page.

The implemented physical width is a parameter, `PA_W`, with a default of 36. Entry address bits between that width and bit 51 are reserved and must be zero. Only one translation is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read goes to `{req_root[PA_W-1:5], 5'b0} + vaddr[31:30]*8`. Root bits 4:0 have no effect.
- R3: Later reads go to `{entry[PA_W-1:12], 12'b0} + idx*8`, where `entry` is the previous level's entry. The index is `vaddr[29:21]` for the directory and `vaddr[20:12]` for the page table. For a 4 KiB mapping exactly three reads are made, in the order top, directory, page table.
- R4: A successful 4 KiB walk returns:
  - `rsp_paddr = {pte[PA_W-1:12], vaddr[11:0]}`;
  - `rsp_large = 0`, `rsp_fault = 0` and `rsp_level = 2`.
  Entry bits outside 51:12, other than bits 0 and 7, have no effect on the address.
- R5: A present directory entry with bit 7 set ends the walk after two reads. It returns:
  - `rsp_paddr = {pde[PA_W-1:21], vaddr[20:0]}`;
  - `rsp_large = 1` and `rsp_level = 1`.
- R6: An entry with bit 0 (present) clear ends the walk with no further reads. The response has `rsp_fault = 1`, and `rsp_level` gives the level that failed (0 = top, 1 = directory, 2 = page table). On any fault, `rsp_paddr` and `rsp_large` are 0.
- R7: An entry with any bit in `PA_W`..51 set faults at its level, even when it is present.
- R8: A large-page directory entry with any of bits 20:12 set faults at level 1.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after the response handshake.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable. `rsp_valid` drops after the handshake.
- R11: The memory port may stall requests and delay responses by any number of cycles. `mem_req_valid` and `mem_req_addr` stay stable while the request is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | PA_W | Table-root base (bits 4:0 unused) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address |
| rsp_large | output | 1 | 2 MiB page mapping |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 2 | Level where the walk ended |

## Verification
The bench builds the walker with the default width of 36 bits. This makes frames above the 4 GiB line reachable, so zero-extension and the upper address bits can be checked. It also leaves bits 36 to 51 of each entry as reserved bits, and the bench sets one of them to provoke a fault. The memory model inserts request stalls and response delays. It also logs every read address, so the number and order of reads can be checked for each outcome.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic [PA_W-1:0] req_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_large,
  output logic            rsp_fault,
  output logic [1:0]      rsp_level
);
  localparam int FR_W = PA_W - 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [31:0]     va;
  logic [PA_W-1:0] base;
  logic [1:0]      lvl;
  logic [8:0]      idx;

  logic [63:0] e;
  logic        e_present, e_rsv, e_big, e_misal;

  always_comb begin
    case (lvl)
      2'd0:    idx = {7'd0, va[31:30]};
      2'd1:    idx = va[29:21];
      default: idx = va[20:12];
    endcase
  end

  assign e         = mem_rsp_data;
  assign e_present = e[0];
  assign e_rsv     = |(e[51:12] >> FR_W);
  assign e_big     = (lvl == 2'd1) && e[7];
  assign e_misal   = |e[20:12];

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = base + {{(PA_W-12){1'b0}}, idx, 3'b000};
  assign rsp_valid     = (st == S_RESP);

  logic unused_bits;
  assign unused_bits = ^{e[63:52], e[11:8], e[6:1], req_root[4:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va        <= '0;
      base      <= '0;
      lvl       <= '0;
      rsp_paddr <= '0;
      rsp_large <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_level <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va   <= req_vaddr;
          base <= {req_root[PA_W-1:5], 5'b0};
          lvl  <= 2'd0;
          st   <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rsp_level <= lvl;
          if (!e_present || e_rsv || (e_big && e_misal)) begin
            rsp_fault <= 1'b1;
            rsp_large <= 1'b0;
            rsp_paddr <= '0;
            st        <= S_RESP;
          end else if (e_big) begin
            rsp_fault <= 1'b0;
            rsp_large <= 1'b1;
            rsp_paddr <= {e[PA_W-1:21], va[20:0]};
            st        <= S_RESP;
          end else if (lvl == 2'd2) begin
            rsp_fault <= 1'b0;
            rsp_large <= 1'b0;
            rsp_paddr <= {e[PA_W-1:12], va[11:0]};
            st        <= S_RESP;
          end else begin
            base <= {e[PA_W-1:12], 12'b0};
            lvl  <= lvl + 2'd1;
            st   <= S_REQ;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_large,
  input logic            rsp_fault,
  input logic [1:0]      rsp_level
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));
  // R2
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  busy_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_large) && $stable(rsp_fault) && $stable(rsp_level)));
  // R10
  rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);
  // R11
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R6
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_level != 2'd3 && rsp_paddr == '0 && !rsp_large));
  // R5
  large_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_large) |-> (!rsp_fault && rsp_level == 2'd1));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_large(rsp_large), .rsp_fault(rsp_fault),
  .rsp_level(rsp_level)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int PA_W = 36;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_vaddr = '0;
  logic [PA_W-1:0] req_root = '0;
  logic            mem_req_valid;
  logic            mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid;
  logic [63:0]     mem_rsp_data;
  logic            rsp_valid;
  logic            rsp_ready = 1'b0;
  logic [PA_W-1:0] rsp_paddr;
  logic            rsp_large;
  logic            rsp_fault;
  logic [1:0]      rsp_level;

  always #4 clk = ~clk;

  pt_walker #(.PA_W(PA_W)) i_pt_walker (.*);

  int ntests = 0;
  int nfail  = 0;
  int stall  = 0;
  int lat    = 0;
  int rd_n   = 0;
  int busy_err = 0;
  logic [PA_W-1:0] rd_addr [0:7];
  logic [63:0] mem [logic [PA_W-1:0]];

  logic [PA_W-1:0] o_paddr;
  logic o_large, o_fault;
  logic [1:0] o_level;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        logic [PA_W-1:0] a;
        repeat (stall) @(negedge clk);
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        if (rd_n < 8) rd_addr[rd_n] = a;
        rd_n++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 64'd0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [PA_W-1:0] root, input int hold);
    int guard = 0;
    rd_n = 0;
    busy_err = 0;
    @(negedge clk);
    req_vaddr = va;
    req_root  = root;
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 500) begin
      if (req_ready) busy_err++;
      @(negedge clk);
      guard++;
    end
    if (req_ready) busy_err++;
    o_paddr = rsp_paddr; o_large = rsp_large; o_fault = rsp_fault; o_level = rsp_level;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_paddr !== o_paddr || rsp_fault !== o_fault || req_ready) busy_err++;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 rsp_valid after handshake", rsp_valid, 0);
    chk("R9 req_ready after handshake", req_ready, 1);
  endtask

  function automatic logic [PA_W-1:0] ent_addr(input logic [63:0] e, input logic [8:0] i);
    return {e[PA_W-1:12], 12'b0} + PA_W'(i) * 8;
  endfunction

  localparam logic [PA_W-1:0] ROOT = 36'h0_1000_001F;
  localparam logic [PA_W-1:0] BASE = 36'h0_1000_0000;
  localparam logic [63:0] E0 = 64'h8000_0000_2000_0027;
  localparam logic [63:0] E1 = 64'h0000_0008_4000_0003;
  localparam logic [63:0] E2 = 64'h0000_000F_FFFF_F861;
  localparam logic [31:0] VA4K = 32'hC0A0_3ABC;
  localparam logic [31:0] VABIG = 32'h4123_4567;
  localparam logic [63:0] EB0 = 64'h0000_0000_3000_0001;
  localparam logic [63:0] EB1 = 64'h0000_0009_A020_0081;

  task automatic load_4k(input logic [63:0] e1, input logic [63:0] e2);
    mem[BASE + PA_W'(VA4K[31:30]) * 8] = E0;
    mem[ent_addr(E0, VA4K[29:21])] = e1;
    mem[ent_addr(e1, VA4K[20:12])] = e2;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_walk_4k(input int st, input int lt, input string tag);
    stall = st; lat = lt;
    load_4k(E1, E2);
    walk(VA4K, ROOT, 0);
    chk({"R3 read count ", tag}, rd_n, 3);
    chk({"R2 top read addr ", tag}, rd_addr[0], BASE + 36'h18);
    chk({"R3 dir read addr ", tag}, rd_addr[1], ent_addr(E0, VA4K[29:21]));
    chk({"R3 pt read addr ", tag}, rd_addr[2], ent_addr(E1, VA4K[20:12]));
    chk({"R4 paddr ", tag}, o_paddr, {E2[PA_W-1:12], VA4K[11:0]});
    chk({"R4 large/fault/level ", tag}, {o_large, o_fault, o_level}, {1'b0, 1'b0, 2'd2});
    chk({"R9 busy ", tag}, busy_err, 0);
    stall = 0; lat = 0;
  endtask

  task automatic t_large;
    mem[BASE + 36'h8] = EB0;
    mem[ent_addr(EB0, VABIG[29:21])] = EB1;
    walk(VABIG, ROOT, 0);
    chk("R5 read count", rd_n, 2);
    chk("R5 paddr", o_paddr, {EB1[PA_W-1:21], VABIG[20:0]});
    chk("R5 large/fault/level", {o_large, o_fault, o_level}, {1'b1, 1'b0, 2'd1});
  endtask

  task automatic t_misaligned;
    mem[ent_addr(EB0, VABIG[29:21])] = EB1 | 64'h1000;
    walk(VABIG, ROOT, 0);
    chk("R8 read count", rd_n, 2);
    chk("R8 large/fault/level", {o_large, o_fault, o_level}, {1'b0, 1'b1, 2'd1});
    chk("R8 paddr zero", o_paddr, 0);
    mem[ent_addr(EB0, VABIG[29:21])] = EB1;
  endtask

  task automatic t_not_present;
    walk(32'h0000_1234, ROOT, 0);
    chk("R6 level0 reads", rd_n, 1);
    chk("R6 level0 fault", {o_large, o_fault, o_level}, {1'b0, 1'b1, 2'd0});
    load_4k(E1, E2 & ~64'h1);
    walk(VA4K, ROOT, 0);
    chk("R6 level2 reads", rd_n, 3);
    chk("R6 level2 fault", {o_large, o_fault, o_level}, {1'b0, 1'b1, 2'd2});
    chk("R6 level2 paddr zero", o_paddr, 0);
  endtask

  task automatic t_reserved;
    load_4k(E1 | 64'h0000_0100_0000_0000, E2);
    walk(VA4K, ROOT, 0);
    chk("R7 read count", rd_n, 2);
    chk("R7 fault level1", {o_large, o_fault, o_level}, {1'b0, 1'b1, 2'd1});
    load_4k(E1, E2);
  endtask

  task automatic t_root_low_bits;
    load_4k(E1, E2);
    walk(VA4K, BASE, 0);
    chk("R2 root low bits ignored", rd_addr[0], BASE + 36'h18);
    chk("R2 same paddr", o_paddr, {E2[PA_W-1:12], VA4K[11:0]});
  endtask

  task automatic t_hold;
    load_4k(E1, E2);
    walk(VA4K, ROOT, 4);
    chk("R10 held response stable", busy_err, 0);
    chk("R10 paddr", o_paddr, {E2[PA_W-1:12], VA4K[11:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_4k(0, 0, "no wait");
    t_walk_4k(3, 5, "wait R11");
    t_large();
    t_misaligned();
    t_not_present();
    t_reserved();
    t_root_low_bits();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    ntests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule